// File: doc/BRIEF.md
# OTP Program Command Sequencer

This block runs on the host side and steps a register-mapped NAND flash controller through a one-time-programmable block program. A single `start_i` pulse starts the script. The block selects block 0, sets the page address with a zero sector field, points the buffer window at the OTP sector and enters OTP access. It then asks the user logic to fill the device buffer RAM and waits for `load_done_i`. After that it issues the program command and polls the interrupt register until the completion bit is set. It clears that register, unless auto-interrupt mode is selected, and reads the controller status word. It always finishes by writing a core-reset command, which takes the device out of OTP mode.

The register bus is simple and synchronous. Each write or read access occupies exactly one clock cycle. Read data is returned in the cycle after the read strobe. The outcome appears on `pass_o`, `err_o`, `lock_o` and `tmo_o`. It is valid when `done_o` pulses and is held until the next accepted start. A poll limit protects against a device that never reports completion.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset, and while `rst_ni` is low, both bus strobes, `load_req_o`, `done_o`, `pass_o`, `err_o`, `lock_o` and `tmo_o` are all 0.
- R2: An accepted start issues four writes on consecutive cycles, in this order:
  - address F100h with 0000h;
  - address F107h with the page in bits [7:2] and 0 in bits [1:0] and [15:8];
  - address F200h with 0800h;
  - address F220h with 0065h.
- R3: After the OTP entry write, `load_req_o` stays high until `load_done_i` is seen high. The program command is never written before that.
- R4: The cycle after `load_done_i`, F220h is written with 0080h. The block then reads F241h every second cycle until a returned word has bit 15 set.
- R5: With `AUTO_INT` = 0, the completion read is followed by a write of 0000h to F241h. With `AUTO_INT` = 1, no write to F241h occurs.
- R6: The status word read from F240h is decoded as follows:
  - bit 10 = 0 gives `pass_o` = 1;
  - bit 10 = 1 gives `err_o` = 1;
  - `lock_o` = 1 only when bits 14 and 10 are both 1.
- R7: If `POLL_MAX` reads of F241h all return bit 15 = 0:
  - `tmo_o` and `err_o` go to 1 and `pass_o` and `lock_o` stay 0;
  - F240h is not read.
- R8: Every run ends with a write of `RST_CMD` to F220h. `done_o` is high for exactly one cycle, in the cycle after that write.
- R8 (continued): the result outputs hold their value after `done_o` until the next start.
- R9: No two bus strobes are ever high together. No access is repeated on back-to-back cycles.
- R10: `start_i` is ignored while a run is in progress. The register script is neither restarted nor repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle start request |
| page_i | input | PAGE_W | OTP page to program, sampled at start |
| load_req_o | output | 1 | Buffer RAM may be filled now |
| load_done_i | input | 1 | User logic has finished filling the buffer |
| bus_addr_o | output | 16 | Register address |
| bus_wdata_o | output | 16 | Register write data |
| bus_we_o | output | 1 | One-cycle write strobe |
| bus_re_o | output | 1 | One-cycle read strobe |
| bus_rdata_i | input | 16 | Read data, valid the cycle after `bus_re_o` |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Program succeeded |
| err_o | output | 1 | Program failed or timed out |
| lock_o | output | 1 | The OTP block was locked |
| tmo_o | output | 1 | Completion bit never seen |

## Verification
A wrong state register shows up on the bus within one cycle. It appears as a write with an address or data out of order, a missing write, a duplicated write, or a read from the wrong register. For that reason the bench records every access in order and compares the whole trace against the script.

A wrong poll counter changes the number of F241h reads before the timeout. A wrong status decode shows on the result outputs at the `done_o` pulse, and those outputs are checked again several cycles later for retention.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
  localparam logic [15:0] A_BLK  = 16'hF100;
  localparam logic [15:0] A_PAGE = 16'hF107;
  localparam logic [15:0] A_BUF  = 16'hF200;
  localparam logic [15:0] A_CMD  = 16'hF220;
  localparam logic [15:0] A_STAT = 16'hF240;
  localparam logic [15:0] A_INT  = 16'hF241;

  localparam logic [15:0] C_OTP   = 16'h0065;
  localparam logic [15:0] C_PRG   = 16'h0080;
  localparam logic [15:0] BUF_CFG = 16'h0800;

  localparam int INT_BIT  = 15;
  localparam int LOCK_BIT = 14;
  localparam int ERR_BIT  = 10;

  typedef enum logic [3:0] {
    S_IDLE, S_BLK, S_PAGE, S_BUF, S_OTP, S_LOAD, S_PRG,
    S_PRD, S_PCHK, S_CLR, S_SRD, S_SCHK, S_RST, S_DONE
  } seq_state_e;
endpackage

// File: rtl/otp_poll_timer.sv
module otp_poll_timer #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic last_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (step_i && !last_o) cnt_q <= cnt_q + 1'b1;
  end

  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/otp_stat_dec.sv
module otp_stat_dec (
  input  logic err_bit_i,
  input  logic lock_bit_i,
  output logic pass_o,
  output logic err_o,
  output logic lock_o
);
  assign pass_o = !err_bit_i;
  assign err_o  = err_bit_i;
  // lock is only reported together with a failed program
  assign lock_o = err_bit_i && lock_bit_i;
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_seq_pkg::*;
#(
  parameter int unsigned PAGE_W   = 6,
  parameter int unsigned POLL_MAX = 1000,
  parameter logic [15:0] RST_CMD  = 16'h00F0,
  parameter bit          AUTO_INT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              load_req_o,
  input  logic              load_done_i,
  output logic [15:0]       bus_addr_o,
  output logic [15:0]       bus_wdata_o,
  output logic              bus_we_o,
  output logic              bus_re_o,
  input  logic [15:0]       bus_rdata_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              err_o,
  output logic              lock_o,
  output logic              tmo_o
);
  seq_state_e state_q, state_d;
  logic [PAGE_W-1:0] page_q;
  logic poll_last, int_seen;
  logic dec_pass, dec_err, dec_lock;
  logic unused_rdata;

  assign int_seen     = bus_rdata_i[INT_BIT];
  assign unused_rdata = ^{bus_rdata_i[13:11], bus_rdata_i[9:0]};

  otp_poll_timer #(.LIMIT(POLL_MAX)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == S_PRG),
    .step_i (state_q == S_PCHK && !int_seen),
    .last_o (poll_last)
  );

  otp_stat_dec u_dec (
    .err_bit_i  (bus_rdata_i[ERR_BIT]),
    .lock_bit_i (bus_rdata_i[LOCK_BIT]),
    .pass_o     (dec_pass),
    .err_o      (dec_err),
    .lock_o     (dec_lock)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start_i) state_d = S_BLK;
      S_BLK:   state_d = S_PAGE;
      S_PAGE:  state_d = S_BUF;
      S_BUF:   state_d = S_OTP;
      S_OTP:   state_d = S_LOAD;
      S_LOAD:  if (load_done_i) state_d = S_PRG;
      S_PRG:   state_d = S_PRD;
      S_PRD:   state_d = S_PCHK;
      S_PCHK: begin
        if (int_seen)       state_d = AUTO_INT ? S_SRD : S_CLR;
        else if (poll_last) state_d = S_RST;
        else                state_d = S_PRD;
      end
      S_CLR:   state_d = S_SRD;
      S_SRD:   state_d = S_SCHK;
      S_SCHK:  state_d = S_RST;
      S_RST:   state_d = S_DONE;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // one register access per state, decoded straight from the state
  always_comb begin
    bus_we_o    = 1'b0;
    bus_re_o    = 1'b0;
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    unique case (state_q)
      S_BLK:  begin bus_we_o = 1'b1; bus_addr_o = A_BLK; end
      S_PAGE: begin bus_we_o = 1'b1; bus_addr_o = A_PAGE; bus_wdata_o = 16'({page_q, 2'b00}); end
      S_BUF:  begin bus_we_o = 1'b1; bus_addr_o = A_BUF; bus_wdata_o = BUF_CFG; end
      S_OTP:  begin bus_we_o = 1'b1; bus_addr_o = A_CMD; bus_wdata_o = C_OTP; end
      S_PRG:  begin bus_we_o = 1'b1; bus_addr_o = A_CMD; bus_wdata_o = C_PRG; end
      S_PRD:  begin bus_re_o = 1'b1; bus_addr_o = A_INT; end
      S_CLR:  begin bus_we_o = 1'b1; bus_addr_o = A_INT; end
      S_SRD:  begin bus_re_o = 1'b1; bus_addr_o = A_STAT; end
      S_RST:  begin bus_we_o = 1'b1; bus_addr_o = A_CMD; bus_wdata_o = RST_CMD; end
      default: ;
    endcase
  end

  assign load_req_o = (state_q == S_LOAD);
  assign done_o     = (state_q == S_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      page_q  <= '0;
      pass_o  <= 1'b0;
      err_o   <= 1'b0;
      lock_o  <= 1'b0;
      tmo_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && start_i) begin
        page_q <= page_i;
        pass_o <= 1'b0;
        err_o  <= 1'b0;
        lock_o <= 1'b0;
        tmo_o  <= 1'b0;
      end else if (state_q == S_SCHK) begin
        pass_o <= dec_pass;
        err_o  <= dec_err;
        lock_o <= dec_lock;
      end else if (state_q == S_PCHK && !int_seen && poll_last) begin
        err_o <= 1'b1;
        tmo_o <= 1'b1;
      end
    end
  end

  a_r9_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_o && bus_re_o));
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_reset_before_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(bus_we_o && bus_addr_o == A_CMD && bus_wdata_o == RST_CMD));
  a_r3_prg_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o && bus_addr_o == A_CMD && bus_wdata_o == C_PRG) |-> $past(load_done_i));
  a_r6_lock_implies_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> err_o);
  a_r6_pass_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && err_o));
  a_r7_tmo_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |-> (err_o && !pass_o && !lock_o));
endmodule

// File: tb/otp_prog_seq_test.sv
module otp_prog_seq_test;
  localparam int CLK_P = 10;
  localparam int POLL_MAX = 8;
  localparam logic [15:0] RST_CMD = 16'h00F0;

  typedef struct packed {
    logic [7:0]  dly;
    logic [15:0] stat;
    logic [5:0]  page;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{8'd0,  16'h0000, 6'd5},
    '{8'd2,  16'h0400, 6'd63},
    '{8'd5,  16'h4400, 6'd0},
    '{8'd7,  16'h4000, 6'd21},
    '{8'd8,  16'h0000, 6'd9},
    '{8'd20, 16'h4400, 6'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, load_done = 1'b0;
  logic [5:0] page = '0;
  logic load_req, we, re, done, pass, err, lock, tmo;
  logic [15:0] addr, wdata, rdata;

  logic start_a = 1'b0;
  logic load_req_a, we_a, re_a, done_a, pass_a, err_a, lock_a, tmo_a;
  logic [15:0] addr_a, wdata_a, rdata_a;

  int checks = 0, errors = 0;
  int dly = 0;
  logic [15:0] stat = '0;
  int pr = 0;
  logic clr_log = 1'b0;

  logic [15:0] wa [16];
  logic [15:0] wd [16];
  int wn = 0, n241 = 0, n240 = 0, ndone = 0;
  bit load_seen = 0, early = 0, bad = 0, pwe = 0;
  logic [15:0] pa = '0, pd = '0;
  int wn_a = 0;
  bit clr241_a = 0;

  always #(CLK_P/2) clk = ~clk;

  otp_prog_seq #(.PAGE_W(6), .POLL_MAX(POLL_MAX), .RST_CMD(RST_CMD), .AUTO_INT(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .page_i(page),
    .load_req_o(load_req), .load_done_i(load_done),
    .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_we_o(we), .bus_re_o(re),
    .bus_rdata_i(rdata), .done_o(done), .pass_o(pass), .err_o(err),
    .lock_o(lock), .tmo_o(tmo));

  otp_prog_seq #(.PAGE_W(6), .POLL_MAX(POLL_MAX), .RST_CMD(RST_CMD), .AUTO_INT(1'b1)) uut_auto (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_a), .page_i(6'd3),
    .load_req_o(load_req_a), .load_done_i(1'b1),
    .bus_addr_o(addr_a), .bus_wdata_o(wdata_a), .bus_we_o(we_a), .bus_re_o(re_a),
    .bus_rdata_i(rdata_a), .done_o(done_a), .pass_o(pass_a), .err_o(err_a),
    .lock_o(lock_a), .tmo_o(tmo_a));

  // device models: registered read data
  always @(posedge clk) begin
    if (start) pr <= 0;
    if (re) begin
      if (addr == 16'hF241) begin
        rdata <= (pr >= dly) ? 16'h8000 : 16'h0000;
        pr <= pr + 1;
      end else if (addr == 16'hF240) rdata <= stat;
      else rdata <= '0;
    end
  end

  always @(posedge clk) begin
    if (re_a) rdata_a <= (addr_a == 16'hF241) ? 16'h8000 : 16'h0000;
  end

  always @(negedge clk) begin
    if (clr_log) begin
      wn = 0; n241 = 0; n240 = 0; ndone = 0;
      load_seen = 0; early = 0; bad = 0; pwe = 0;
      wn_a = 0; clr241_a = 0;
    end else begin
      if (we) begin
        if (wn < 16) begin wa[wn] = addr; wd[wn] = wdata; end
        wn++;
        if (addr == 16'hF220 && wdata == 16'h0080 && !load_seen) early = 1;
      end
      if (load_done) load_seen = 1;
      if (re) begin
        if (addr == 16'hF241) n241++;
        else if (addr == 16'hF240) n240++;
      end
      if (done) ndone++;
      if (we && re) bad = 1;
      if (we && pwe && addr == pa && wdata == pd) bad = 1;
      pwe = we; pa = addr; pd = wdata;
      if (we_a) begin
        wn_a++;
        if (addr_a == 16'hF241) clr241_a = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input bit busy_start, input int k);
    logic [15:0] ea [8];
    logic [15:0] ed [8];
    string er [8];
    int ne;
    bit t_o;
    bit e_pass, e_err, e_lock;
    int e241;
    dly = int'(v.dly); stat = v.stat; page = v.page;
    t_o = (dly >= POLL_MAX);
    e_pass = !t_o && !v.stat[10];
    e_err  = t_o || v.stat[10];
    e_lock = !t_o && v.stat[10] && v.stat[14];
    e241   = t_o ? POLL_MAX : dly + 1;
    ea[0] = 16'hF100; ed[0] = 16'h0000; er[0] = "R2";
    ea[1] = 16'hF107; ed[1] = {8'h00, v.page, 2'b00}; er[1] = "R2";
    ea[2] = 16'hF200; ed[2] = 16'h0800; er[2] = "R2";
    ea[3] = 16'hF220; ed[3] = 16'h0065; er[3] = "R2";
    ea[4] = 16'hF220; ed[4] = 16'h0080; er[4] = "R4";
    ne = 5;
    if (!t_o) begin ea[ne] = 16'hF241; ed[ne] = 16'h0000; er[ne] = "R5"; ne++; end
    ea[ne] = 16'hF220; ed[ne] = RST_CMD; er[ne] = "R8"; ne++;

    @(posedge clk); #1 clr_log = 1; start = 1;
    @(posedge clk); #1 clr_log = 0; start = 0;
    while (!load_req) begin @(posedge clk); #1; end
    repeat (k) begin @(posedge clk); #1; end
    chk(load_req && wn == 4 && !early, "R3", "load_req held, no program yet", {load_req, 8'(wn)}, {1'b1, 8'd4});
    load_done = 1; start = busy_start;
    @(posedge clk); #1 load_done = 0; start = 0;
    @(negedge clk);
    while (!done) @(negedge clk);
    chk(pass == e_pass && err == e_err && lock == e_lock, "R6", "pass/err/lock",
        {pass, err, lock}, {e_pass, e_err, e_lock});
    chk(tmo == t_o, "R7", "tmo", tmo, t_o);
    chk(n241 == e241, "R4", "F241 reads", n241, e241);
    chk(n240 == (t_o ? 0 : 1), "R7", "F240 reads", n240, t_o ? 0 : 1);
    chk(wn == ne, busy_start ? "R10" : "R8", "write count", wn, ne);
    for (int j = 0; j < ne; j++)
      chk(wa[j] == ea[j] && wd[j] == ed[j], er[j], "write trace", {wa[j], wd[j]}, {ea[j], ed[j]});
    repeat (3) @(negedge clk);
    chk(ndone == 1, "R8", "done pulse cycles", ndone, 1);
    chk(pass == e_pass && err == e_err && lock == e_lock && tmo == t_o, "R8", "held result",
        {pass, err, lock, tmo}, {e_pass, e_err, e_lock, t_o});
    chk(!bad, "R9", "strobe overlap or repeat", bad, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 3);
    chk(!we && !re && !load_req && !done && !pass && !err && !lock && !tmo, "R1", "in reset",
        {we, re, load_req, done, pass, err, lock, tmo}, 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(!we && !re && !load_req && !done && !pass && !err && !lock && !tmo, "R1", "after reset",
        {we, re, load_req, done, pass, err, lock, tmo}, 0);

    for (int i = 0; i < 6; i++) run_vec(VEC[i], i == 2, i);

    // R5: auto-interrupt instance skips the clear write
    @(posedge clk); #1 clr_log = 1; start_a = 1;
    @(posedge clk); #1 clr_log = 0; start_a = 0;
    @(negedge clk);
    while (!done_a) @(negedge clk);
    chk(!clr241_a, "R5", "auto mode F241 write", clr241_a, 0);
    chk(wn_a == 6, "R5", "auto mode write count", wn_a, 6);
    chk(pass_a && !err_a, "R6", "auto mode pass", {pass_a, err_a}, 2'b10);

    // R1: reset in the middle of a run
    dly = 3; stat = 16'h0400; page = 6'd7;
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
    while (!load_req) begin @(posedge clk); #1; end
    rst_n = 0; #1;
    chk(!we && !re && !load_req && !done && !pass && !err && !lock && !tmo, "R1", "mid-run reset",
        {we, re, load_req, done, pass, err, lock, tmo}, 0);
    @(posedge clk); #1 rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!we && !re && !load_req, "R1", "idle after reset", {we, re, load_req}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule